// File: doc/BRIEF.md
# Active Energy Pulse Generator

This block turns a stream of signed active-power samples into a train of fixed-width energy pulses. A sample is taken on each cycle where `smp_valid_i` is high. It is first conditioned: small magnitudes are squelched to zero, and the selected accumulation mode is applied. It is then multiplied by a divider value and added into an energy accumulator. Each time the accumulator reaches one energy quantum, the quantum is subtracted and one pulse is requested on `cf_o`. Because the divider scales every addition, doubling the divider doubles the pulse rate.

Two further functions run on the same samples. A reverse-power flag shows whether the latest sample was negative with a magnitude above a programmable threshold. A no-load timer counts consecutive squelched samples and, after a programmable time, clears any fractional energy left in the accumulator. All configuration arrives on plain input buses, which are expected to be driven by a register bank elsewhere. The power-on value of the creep configuration in that bank is FFF02Bh.

Top module: `energy_pulse_gen`

## Requirements
- R1: During and after reset, `cf_o` and `rev_o` are low and the energy accumulator is empty.
- R2: Each valid sample adds its conditioned magnitude multiplied by `cfg_div_i` into the accumulator. Each time the accumulator reaches 2^QUANTUM_LOG2, that amount is removed and one pulse is emitted, and the remainder is kept. After N equal samples, the pulse count is floor(N·mag·div / 2^QUANTUM_LOG2).
- R3: Doubling `cfg_div_i` with the same samples doubles the number of pulses.
- R4: A sample whose magnitude is below `cfg_creep_i[11:0]` shifted left by PWR_W−12 bits contributes zero energy. A magnitude equal to that value is not squelched.
- R5: Mode code 00 accumulates the magnitude, so negative samples count as positive. Codes 10 and 11 behave like 00.
- R6: Mode code 01 accumulates positive samples only. A negative sample adds nothing.
- R7: After each valid sample, `rev_o` is high exactly when the sample is negative and its magnitude is strictly greater than `cfg_rev_thr_i` shifted left by PWR_W−12 bits. The value is held until the next valid sample, in every mode.
- R8: When `cfg_creep_i[23:12]` is nonzero, a run of that many times CREEP_TICK_SAMPLES consecutive squelched samples clears the accumulator. A non-squelched sample restarts the run. A value of 0 disables the clear.
- R9: Each pulse lasts `cfg_pulse_clks_i` clocks, with 0 meaning 1. At least one low clock separates two pulses. A crossing that occurs during a pulse is held and emitted after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Power sample strobe |
| smp_power_i | input | PWR_W | Signed two's-complement active power |
| cfg_div_i | input | DIV_W | Energy divider; scales every addition |
| cfg_creep_i | input | 24 | [23:12] creep time in ticks, [11:0] no-load threshold |
| cfg_mode_i | input | 2 | 01 positive only, other codes absolute |
| cfg_rev_thr_i | input | THR_W | Reverse-power threshold |
| cfg_pulse_clks_i | input | PW_W | Pulse width in clocks |
| cf_o | output | 1 | Energy pulse output |
| rev_o | output | 1 | Reverse-power flag |

## Verification
Two functions can act on the same sample. In absolute mode, a large negative sample both raises the reverse flag and causes an energy crossing. The bench drives one such sample and requires both `rev_o` high and exactly one pulse. The pulse shaper can also receive a crossing while it is still driving a pulse. Two back-to-back samples, each worth exactly one quantum and sent with a long pulse width, provoke this case. The bench then requires two pulses, each of the full width.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam logic [1:0] MODE_POS_ONLY = 2'b01;
  localparam int unsigned CFG_THR_W = 12;
endpackage

// File: rtl/epg_power_cond.sv
module epg_power_cond #(
  parameter int unsigned PWR_W = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          valid_i,
  input  logic [PWR_W-1:0]              power_i,
  input  logic [epg_pkg::CFG_THR_W-1:0] nl_thr_i,
  input  logic [epg_pkg::CFG_THR_W-1:0] rev_thr_i,
  input  logic [1:0]                    mode_i,
  output logic [PWR_W-1:0]              add_mag_o,
  output logic                          squelch_o,
  output logic                          rev_o
);
  localparam int unsigned ALIGN = PWR_W - epg_pkg::CFG_THR_W;

  logic             neg;
  logic [PWR_W-1:0] mag;
  logic [PWR_W-1:0] nl_scaled;
  logic [PWR_W-1:0] rev_scaled;
  logic             rev_d;
  logic             rev_q;

  always_comb begin
    neg        = power_i[PWR_W-1];
    mag        = neg ? (~power_i + 1'b1) : power_i;
    nl_scaled  = {nl_thr_i, {ALIGN{1'b0}}};
    rev_scaled = {rev_thr_i, {ALIGN{1'b0}}};
    squelch_o  = (mag < nl_scaled);
    if (squelch_o || (neg && mode_i == epg_pkg::MODE_POS_ONLY)) begin
      add_mag_o = '0;
    end else begin
      add_mag_o = mag;
    end
    rev_d = valid_i ? (neg && (mag > rev_scaled)) : rev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rev_q <= 1'b0;
    else        rev_q <= rev_d;
  end

  assign rev_o = rev_q;

  AST_REV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(rev_o)); // R7
  AST_POS_MODE_BLOCKS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == epg_pkg::MODE_POS_ONLY && power_i[PWR_W-1]) |-> (add_mag_o == '0)); // R6
endmodule

// File: rtl/epg_creep_timer.sv
module epg_creep_timer #(
  parameter int unsigned TICK_SAMPLES = 4600
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          valid_i,
  input  logic                          squelch_i,
  input  logic [epg_pkg::CFG_THR_W-1:0] units_thr_i,
  output logic                          clr_o
);
  localparam int unsigned SUB_W = (TICK_SAMPLES > 1) ? $clog2(TICK_SAMPLES) : 1;
  localparam int unsigned UW    = epg_pkg::CFG_THR_W;

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [UW-1:0]    units_q, units_d;

  always_comb begin
    sub_d   = sub_q;
    units_d = units_q;
    clr_o   = 1'b0;
    if (valid_i) begin
      if (!squelch_i || units_thr_i == '0) begin
        sub_d   = '0;
        units_d = '0;
      end else if (sub_q == SUB_W'(TICK_SAMPLES - 1)) begin
        sub_d = '0;
        if (units_q + 1'b1 == units_thr_i) begin
          units_d = '0;
          clr_o   = 1'b1;
        end else begin
          units_d = units_q + 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      units_q <= '0;
    end else if (valid_i) begin
      sub_q   <= sub_d;
      units_q <= units_d;
    end
  end
endmodule

// File: rtl/epg_energy_acc.sv
module epg_energy_acc #(
  parameter int unsigned PWR_W        = 24,
  parameter int unsigned DIV_W        = 12,
  parameter int unsigned QUANTUM_LOG2 = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [PWR_W-1:0] add_mag_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             fire_o
);
  localparam int unsigned PROD_W = PWR_W + DIV_W;
  localparam int unsigned ACC_W  = ((QUANTUM_LOG2 > PROD_W) ? QUANTUM_LOG2 : PROD_W) + 1;
  localparam logic [ACC_W-1:0] QUANTUM = ACC_W'(1) << QUANTUM_LOG2;

  logic [PROD_W-1:0] add;
  logic [ACC_W-1:0]  sum;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              fire_q, fire_d;

  always_comb begin
    add    = PROD_W'(add_mag_i) * PROD_W'(div_i);
    sum    = acc_q + ACC_W'(add);
    acc_d  = acc_q;
    fire_d = 1'b0;
    if (valid_i) begin
      if (clr_i) begin
        acc_d = '0;
      end else if (sum >= QUANTUM) begin
        acc_d  = sum - QUANTUM;
        fire_d = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      if (valid_i) acc_q <= acc_d;
    end
  end

  assign fire_o = fire_q;

  AST_FIRE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(valid_i)); // R2
  AST_CREEP_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && clr_i) |=> (acc_q == '0 && !fire_o)); // R8
endmodule

// File: rtl/epg_pulse_shaper.sv
module epg_pulse_shaper #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic [PW_W-1:0] width_i,
  output logic            cf_o
);
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic [PW_W-1:0] w_eff;
  logic            gap_q, gap_d;
  logic            pend_q, pend_d;
  logic            start;

  always_comb begin
    w_eff  = (width_i == '0) ? PW_W'(1) : width_i;
    start  = (fire_i || pend_q) && (cnt_q == '0) && !gap_q;
    cnt_d  = start ? w_eff : ((cnt_q != '0) ? cnt_q - 1'b1 : '0);
    gap_d  = (cnt_q == PW_W'(1));
    pend_d = start ? (pend_q && fire_i) : (pend_q || fire_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gap_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
      pend_q <= pend_d;
    end
  end

  assign cf_o = (cnt_q != '0);

  AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cf_o) |=> !cf_o); // R9
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int unsigned PWR_W              = 24,
  parameter int unsigned DIV_W              = 12,
  parameter int unsigned QUANTUM_LOG2       = 35,
  parameter int unsigned CREEP_TICK_SAMPLES = 4600,
  parameter int unsigned PW_W               = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_valid_i,
  input  logic [PWR_W-1:0]              smp_power_i,
  input  logic [DIV_W-1:0]              cfg_div_i,
  input  logic [23:0]                   cfg_creep_i,
  input  logic [1:0]                    cfg_mode_i,
  input  logic [epg_pkg::CFG_THR_W-1:0] cfg_rev_thr_i,
  input  logic [PW_W-1:0]               cfg_pulse_clks_i,
  output logic                          cf_o,
  output logic                          rev_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [PWR_W-1:0] add_mag;
  logic             squelch;
  logic             creep_clr;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  epg_power_cond #(.PWR_W(PWR_W)) u_cond (
    .clk(clk), .rst_n(rst_n_s), .valid_i(smp_valid_i), .power_i(smp_power_i),
    .nl_thr_i(cfg_creep_i[11:0]), .rev_thr_i(cfg_rev_thr_i), .mode_i(cfg_mode_i),
    .add_mag_o(add_mag), .squelch_o(squelch), .rev_o(rev_o)
  );

  epg_creep_timer #(.TICK_SAMPLES(CREEP_TICK_SAMPLES)) u_creep (
    .clk(clk), .rst_n(rst_n_s), .valid_i(smp_valid_i), .squelch_i(squelch),
    .units_thr_i(cfg_creep_i[23:12]), .clr_o(creep_clr)
  );

  epg_energy_acc #(.PWR_W(PWR_W), .DIV_W(DIV_W), .QUANTUM_LOG2(QUANTUM_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .valid_i(smp_valid_i), .add_mag_i(add_mag),
    .div_i(cfg_div_i), .clr_i(creep_clr), .fire_o(fire)
  );

  epg_pulse_shaper #(.PW_W(PW_W)) u_shaper (
    .clk(clk), .rst_n(rst_n_s), .fire_i(fire), .width_i(cfg_pulse_clks_i), .cf_o(cf_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n_s |-> (!cf_o && !rev_o)); // R1
endmodule

// File: tb/energy_pulse_gen_tb_top.sv
module energy_pulse_gen_tb_top;
  localparam int QL = 16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [23:0] pw;
  logic [11:0] div;
  logic [23:0] creep;
  logic [1:0]  mode;
  logic [11:0] rthr;
  logic [7:0]  pclk;
  logic        cf, rev;

  int nchecks = 0, nerr = 0, pulses = 0, run = 0, exp_w = 3;
  logic cf_prev = 1'b0;

  always #2.5 clk = ~clk;

  energy_pulse_gen #(.QUANTUM_LOG2(QL), .CREEP_TICK_SAMPLES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .smp_power_i(pw), .cfg_div_i(div),
    .cfg_creep_i(creep), .cfg_mode_i(mode), .cfg_rev_thr_i(rthr), .cfg_pulse_clks_i(pclk),
    .cf_o(cf), .rev_o(rev)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse counter and width monitor (R9)
  always @(negedge clk) begin
    if (cf && !cf_prev) begin pulses++; run = 1; end
    else if (cf) run++;
    else if (cf_prev) check(run == exp_w, "R9 width", run, exp_w);
    cf_prev = cf;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; pw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulses = 0;
  endtask

  task automatic send(input logic [23:0] p, input int idle);
    valid = 1'b1; pw = p;
    @(negedge clk);
    valid = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic burst(input logic [23:0] p, input int n);
    for (int i = 0; i < n; i++) send(p, 8);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; valid = 1'b0; pw = '0; div = 12'd1; creep = 24'h0;
    mode = 2'b00; rthr = 12'hFFF; pclk = 8'd3;
    repeat (2) @(negedge clk);
    check(!cf && !rev, "R1 during reset", {cf, rev}, 0);
    do_reset();
    check(!cf && !rev, "R1 after reset", {cf, rev}, 0);

    // R2/R3: divider sweep, 16 samples of 8192, quantum 65536
    base = 0;
    for (int d = 1; d <= 8; d = d * 2) begin
      div = 12'(d); do_reset();
      burst(24'd8192, 16);
      check(pulses == 2 * d, "R2 pulse count", pulses, 2 * d);
      if (d > 1) check(pulses == 2 * base, "R3 doubling", pulses, 2 * base);
      base = pulses;
    end
    // R2: remainder kept, 10 x 5000 x 3 = 150000 -> 2 pulses
    div = 12'd3; do_reset(); burst(24'd5000, 10);
    check(pulses == 150000 / 65536, "R2 remainder", pulses, 150000 / 65536);

    // R5: absolute mode with negatives, codes 00 and 11
    div = 12'd4;
    mode = 2'b00; do_reset(); burst(-24'sd8192, 8);
    check(pulses == 4, "R5 mode00 negative", pulses, 4);
    mode = 2'b11; do_reset(); burst(-24'sd8192, 8);
    check(pulses == 4, "R5 mode11 negative", pulses, 4);

    // R6: positive-only
    mode = 2'b01; do_reset(); burst(-24'sd8192, 8);
    check(pulses == 0, "R6 negatives ignored", pulses, 0);
    burst(24'd8192, 8);
    check(pulses == 4, "R6 positives counted", pulses, 4);
    mode = 2'b00;

    // R4: no-load threshold 2 -> 8192
    div = 12'd8; creep = {12'd0, 12'd2};
    do_reset(); burst(24'd8191, 16); burst(-24'sd8191, 4);
    check(pulses == 0, "R4 below threshold", pulses, 0);
    burst(24'd8192, 16);
    check(pulses == 16, "R4 equal threshold", pulses, 16);
    creep = 24'h0;

    // R7: reverse threshold 2 -> 8192
    rthr = 12'd2; do_reset();
    send(-24'sd8193, 5); check(rev == 1'b1, "R7 above", rev, 1);
    send(24'd9000, 5);   check(rev == 1'b0, "R7 positive", rev, 0);
    send(-24'sd8192, 5); check(rev == 1'b0, "R7 equal", rev, 0);
    mode = 2'b01;
    send(-24'sd100000, 20); check(rev == 1'b1, "R7 held pos-only mode", rev, 1);
    mode = 2'b00;

    // R8: creep clear, nl=1 (4096), 2 units x 3 samples
    div = 12'd1; creep = {12'd2, 12'd1};
    do_reset(); send(24'd60000, 8);
    for (int i = 0; i < 5; i++) send(24'd0, 2);
    burst(24'd8000, 1);
    check(pulses == 1, "R8 short run keeps energy", pulses, 1);
    do_reset(); send(24'd60000, 8);
    for (int i = 0; i < 6; i++) send(24'd0, 2);
    burst(24'd8000, 1);
    check(pulses == 0, "R8 timeout clears", pulses, 0);
    creep = {12'd0, 12'd1};
    do_reset(); send(24'd60000, 8);
    for (int i = 0; i < 20; i++) send(24'd0, 2);
    burst(24'd8000, 1);
    check(pulses == 1, "R8 disabled", pulses, 1);
    creep = 24'h0;

    // R9: crossing during a pulse is held; width 0 means 1
    div = 12'd8; pclk = 8'd10; exp_w = 10; do_reset();
    send(24'd8192, 0); send(24'd8192, 60);
    check(pulses == 2, "R9 pending pulse", pulses, 2);
    pclk = 8'd0; exp_w = 1; do_reset(); burst(24'd8192, 3);
    check(pulses == 3, "R9 width zero", pulses, 3);

    // same sample: reverse flag and crossing together (R5, R7)
    pclk = 8'd3; exp_w = 3; rthr = 12'd1; do_reset();
    send(-24'sd8192, 0);
    check(rev == 1'b1, "R7 with crossing", rev, 1);
    repeat (30) @(negedge clk);
    check(pulses == 1, "R5 with reverse", pulses, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule